// File: doc/BRIEF.md
# Coherent 64-Line Parallel IO Bank

This block controls 64 general-purpose digital lines through a 32-bit synchronous register port. Each line has its own output-enable bit and output-level bit. A line whose enable is clear is not driven, and the board pull-up sets its level. Every line can be read back as an input whatever its enable, through a two-flop synchronizer. The pad drivers are outside the block. They appear here as a per-line tri-state enable (`pin_oe`), a per-line drive level (`pin_out`) and a per-line pin sample (`pin_in`).

Software reaches the 64 lines as two 32-bit halves. In direct mode every write to a data or enable half reaches the pins at once. In held mode the writes are only staged. The write to the upper data half is the commit: it moves the upper data and all staged halves to the pins on one clock edge, so a 64-bit pattern changes coherently on a 32-bit bus. A loop-back mode turns off all pad drivers and feeds the live output pattern back into the input path for built-in test.

A small state machine follows the commit protocol. Its states are DIRECT, HELD_CLEAN (held mode, nothing staged) and HELD_DIRTY (held mode, staged data waiting). Its transitions are:
- ENTER_HOLD (DIRECT to HELD_CLEAN): a control write with the hold bit set.
- STAGE (HELD_CLEAN or HELD_DIRTY to HELD_DIRTY): a write to the lower data half or to either enable half.
- COMMIT (HELD_CLEAN or HELD_DIRTY to HELD_CLEAN): a write to the upper data half.
- FLUSH_EXIT (HELD_DIRTY to DIRECT, with a commit): a control write with the hold bit clear.
- PLAIN_EXIT (HELD_CLEAN to DIRECT): a control write with the hold bit clear.

Top module: `pio_bank64`

## Requirements
- R1: After reset the pins, the control register and all four readable output halves are zero. Reset also selects direct mode with loop-back off, and `pin_oe` is all zero.
- R2: Register offsets are 1 for data of lines 0-31, 2 for data of lines 32-63, 3 for enables of lines 0-31 and 4 for enables of lines 32-63. Bit k of a half controls line k, or line k+32 for an upper half. `pin_out[i]` carries the line's data bit, and `pin_oe[i]` carries its enable bit when loop-back is off.
- R3: In direct mode (control bit 0 clear), a write to offsets 1-4 shows on the pins right after the write's clock edge, and the other halves do not change.
- R4: In held mode (control bit 0 set), writes to offsets 1, 3 and 4 leave `pin_out` and `pin_oe` unchanged.
- R5: In held mode a write to offset 2 applies, on that one edge, the written upper data together with the last written values of the lower data and of both enable halves.
- R6: A control write that clears bit 0 while staged data is waiting applies all staged halves on that edge.
- R7: A read returns at once the selected value. Offsets 1-4 return the last value written to them. Offset 0 returns bit 0 = hold mode and bit 1 = loop-back, with all other bits zero. Offset 7 returns zero.
- R8: Offsets 5 and 6 return the synchronized inputs of lines 0-31 and 32-63 whatever the enables are. A pin change set up before clock edge k is visible after edge k+1 and not after edge k.
- R9: With loop-back set (control bit 1), `pin_oe` is all zero. The input path then reads, for each line, its output data bit when enabled and 1 (pull-up) when not enabled.
- R10: Writes to offsets 5, 6 and 7 change no pin and no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 64 | Sampled level of each line |
| pin_out | output | 64 | Drive level of each line |
| pin_oe | output | 64 | Drive enable of each line |

## Verification
The bench aims at the commit edge in held mode. There, a design that moved the lower half on its own write, or that used stale upper data at commit, would show a torn 64-bit pattern on the pins. It leaves held mode with staged data waiting, which catches a design that drops those halves instead of flushing them. It measures the synchronizer latency to the exact edge, so an extra or a missing flop shows up. It reads back in loop-back, where a design that ignored the enables would return 0 instead of the pull-up 1 on undriven lines.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam logic [2:0] ADR_CTRL   = 3'd0;
    localparam logic [2:0] ADR_DAT_LO = 3'd1;
    localparam logic [2:0] ADR_DAT_HI = 3'd2;
    localparam logic [2:0] ADR_OE_LO  = 3'd3;
    localparam logic [2:0] ADR_OE_HI  = 3'd4;
    localparam logic [2:0] ADR_IN_LO  = 3'd5;
    localparam logic [2:0] ADR_IN_HI  = 3'd6;

    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_LOOP_BIT = 1;

    localparam int NUM_SLOTS = 4;

    typedef enum logic [1:0] {
        ST_DIRECT     = 2'd0,
        ST_HELD_CLEAN = 2'd1,
        ST_HELD_DIRTY = 2'd2
    } pio_state_e;

endpackage

// File: rtl/pio_commit_fsm.sv
module pio_commit_fsm
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic ctrl_hold,
    input  logic wr_stage,
    input  logic wr_hi_data,
    output logic held,
    output logic commit
);

    pio_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DIRECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DIRECT: begin
                if (wr_ctrl && ctrl_hold) state_d = ST_HELD_CLEAN;
            end
            ST_HELD_CLEAN: begin
                if (wr_ctrl && !ctrl_hold) state_d = ST_DIRECT;
                else if (wr_stage)         state_d = ST_HELD_DIRTY;
            end
            ST_HELD_DIRTY: begin
                if (wr_ctrl && !ctrl_hold) state_d = ST_DIRECT;
                else if (wr_hi_data)       state_d = ST_HELD_CLEAN;
            end
            default: state_d = ST_DIRECT;
        endcase
    end

    always_comb begin
        held   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            ST_DIRECT: begin
                held = 1'b0;
            end
            ST_HELD_CLEAN: begin
                held   = 1'b1;
                commit = wr_hi_data;
            end
            ST_HELD_DIRTY: begin
                held   = 1'b1;
                commit = wr_hi_data || (wr_ctrl && !ctrl_hold);
            end
            default: held = 1'b0;
        endcase
    end

    // R5
    hi_write_cleans_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DIRECT && wr_hi_data) |=> state_q == ST_HELD_CLEAN);

    // R6
    exit_to_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DIRECT && wr_ctrl && !ctrl_hold) |=> state_q == ST_DIRECT);

endmodule

// File: rtl/pio_sync2.sv
module pio_sync2 #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;
    logic [1:0]       warm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            warm_q <= 2'd0;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
            if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end
    end

    assign dout = stab_q;

    // R8
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> dout == $past(din, 2));

endmodule

// File: rtl/pio_pin_drive.sv
module pio_pin_drive #(
    parameter int LINES = 64
) (
    input  logic [LINES-1:0] live_dat,
    input  logic [LINES-1:0] live_oe,
    input  logic             loopback,
    input  logic [LINES-1:0] pin_in,
    output logic [LINES-1:0] pin_out,
    output logic [LINES-1:0] pin_oe,
    output logic [LINES-1:0] in_src
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign pin_out[i] = live_dat[i];
        assign pin_oe[i]  = live_oe[i] & ~loopback;
        assign in_src[i]  = loopback ? (live_dat[i] | ~live_oe[i]) : pin_in[i];
    end

endmodule

// File: rtl/pio_bank64.sv
module pio_bank64
    import pio_pkg::*;
#(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [HALF_W-1:0]   reg_wdata,
    output logic [HALF_W-1:0]   reg_rdata,
    input  logic [2*HALF_W-1:0] pin_in,
    output logic [2*HALF_W-1:0] pin_out,
    output logic [2*HALF_W-1:0] pin_oe
);

    localparam int LINES = 2 * HALF_W;
    localparam int SLOT_DLO = 0;
    localparam int SLOT_DHI = 1;
    localparam int SLOT_OLO = 2;
    localparam int SLOT_OHI = 3;

    logic [HALF_W-1:0] stg_q  [NUM_SLOTS];
    logic [HALF_W-1:0] live_q [NUM_SLOTS];
    logic              loop_q;

    logic wr_ctrl, wr_stage, wr_hi_data;
    logic held, commit;
    logic [LINES-1:0] in_src, in_sync;

    assign wr_ctrl    = reg_wr && (reg_addr == ADR_CTRL);
    assign wr_hi_data = reg_wr && (reg_addr == ADR_DAT_HI);
    assign wr_stage   = reg_wr && ((reg_addr == ADR_DAT_LO) ||
                                   (reg_addr == ADR_OE_LO)  ||
                                   (reg_addr == ADR_OE_HI));

    pio_commit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .ctrl_hold  (reg_wdata[CTRL_HOLD_BIT]),
        .wr_stage   (wr_stage),
        .wr_hi_data (wr_hi_data),
        .held       (held),
        .commit     (commit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                stg_q[s]  <= '0;
                live_q[s] <= '0;
            end
            loop_q <= 1'b0;
        end else begin
            if (wr_ctrl) loop_q <= reg_wdata[CTRL_LOOP_BIT];
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (reg_wr && (reg_addr == 3'(s + 1))) stg_q[s] <= reg_wdata;
                if (commit) begin
                    if (s == SLOT_DHI && wr_hi_data) live_q[s] <= reg_wdata;
                    else                             live_q[s] <= stg_q[s];
                end else if (!held && reg_wr && (reg_addr == 3'(s + 1))) begin
                    live_q[s] <= reg_wdata;
                end
            end
        end
    end

    pio_pin_drive #(.LINES(LINES)) u_drive (
        .live_dat ({live_q[SLOT_DHI], live_q[SLOT_DLO]}),
        .live_oe  ({live_q[SLOT_OHI], live_q[SLOT_OLO]}),
        .loopback (loop_q),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .in_src   (in_src)
    );

    pio_sync2 #(.WIDTH(LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (in_src),
        .dout  (in_sync)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CTRL_HOLD_BIT] = held;
                reg_rdata[CTRL_LOOP_BIT] = loop_q;
            end
            ADR_DAT_LO: reg_rdata = stg_q[SLOT_DLO];
            ADR_DAT_HI: reg_rdata = stg_q[SLOT_DHI];
            ADR_OE_LO:  reg_rdata = stg_q[SLOT_OLO];
            ADR_OE_HI:  reg_rdata = stg_q[SLOT_OHI];
            ADR_IN_LO:  reg_rdata = in_sync[HALF_W-1:0];
            ADR_IN_HI:  reg_rdata = in_sync[LINES-1:HALF_W];
            default:    reg_rdata = '0;
        endcase
    end

    // R4
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && wr_stage) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R5
    commit_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && wr_hi_data) |=>
            (pin_out[HALF_W-1:0] == $past(stg_q[SLOT_DLO]) &&
             pin_out[LINES-1:HALF_W] == $past(reg_wdata)));

    // R3
    direct_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && wr_hi_data) |=> pin_out[LINES-1:HALF_W] == $past(reg_wdata));

    // R9
    loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[CTRL_LOOP_BIT]) |=> pin_oe == '0);

    // R10
    ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr >= ADR_IN_LO) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/pio_bank64_test.sv
module pio_bank64_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out;
    logic [63:0] pin_oe;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_stg  [1:4];
    logic [31:0] m_live [1:4];
    bit          m_hold;
    bit          m_loop;

    always #2.5 clk = ~clk;

    pio_bank64 #(.HALF_W(32)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    function automatic logic [63:0] exp_out();
        return {m_live[2], m_live[1]};
    endfunction

    function automatic logic [63:0] exp_oe();
        return m_loop ? 64'd0 : {m_live[4], m_live[3]};
    endfunction

    function automatic logic [63:0] exp_in();
        return m_loop ? ({m_live[2], m_live[1]} | ~{m_live[4], m_live[3]}) : pin_in;
    endfunction

    function automatic logic [31:0] exp_reg(logic [2:0] a);
        logic [63:0] v;
        v = exp_in();
        case (a)
            3'd0: return {30'd0, m_loop, m_hold};
            3'd1, 3'd2, 3'd3, 3'd4: return m_stg[a];
            3'd5: return v[31:0];
            3'd6: return v[63:32];
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_write(logic [2:0] a, logic [31:0] d);
        case (a)
            3'd0: begin
                if (m_hold && !d[0]) for (int s = 1; s <= 4; s++) m_live[s] = m_stg[s];
                m_hold = d[0];
                m_loop = d[1];
            end
            3'd1, 3'd3, 3'd4: begin
                m_stg[a] = d;
                if (!m_hold) m_live[a] = d;
            end
            3'd2: begin
                m_stg[2] = d;
                if (!m_hold) m_live[2] = d;
                else for (int s = 1; s <= 4; s++) m_live[s] = m_stg[s];
            end
            default: ;
        endcase
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_pins(string req);
        check({req, " pin_out"}, pin_out, exp_out());
        check({req, " pin_oe"}, pin_oe, exp_oe());
    endtask

    task automatic do_write(logic [2:0] a, logic [31:0] d, string req);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
        check_pins(req);
    endtask

    task automatic check_reg(logic [2:0] a, string req);
        reg_addr = a;
        #1;
        check(req, {32'd0, reg_rdata}, {32'd0, exp_reg(a)});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        for (int s = 1; s <= 4; s++) begin
            m_stg[s] = '0;
            m_live[s] = '0;
        end
        m_hold = 0;
        m_loop = 0;

        idle(4);
        rst_n = 1'b1;
        idle(3);

        // R1 reset state
        check_pins("R1 ");
        for (int a = 0; a < 5; a++) check_reg(3'(a), "R1 reset readback");

        // R2 line mapping, R3 direct mode
        do_write(3'd3, 32'h0000_00F0, "R2/R3 oe lo");
        do_write(3'd1, 32'h0000_00A0, "R2/R3 data lo");
        do_write(3'd4, 32'h8000_0001, "R2/R3 oe hi");
        do_write(3'd2, 32'h8000_0000, "R2/R3 data hi");
        check("R2 line 63 driven high", {63'd0, pin_out[63] & pin_oe[63]}, 64'd1);
        check("R2 line 32 driven low", {62'd0, pin_out[32], pin_oe[32]}, 64'd1);

        // R8 synchronizer latency
        pin_in = 64'h0;
        idle(3);
        @(negedge clk);
        pin_in = 64'hDEAD_BEEF_1234_5678;
        @(negedge clk);
        reg_addr = 3'd5;
        #1;
        check("R8 not yet visible after one edge", {32'd0, reg_rdata}, 64'd0);
        @(negedge clk);
        reg_addr = 3'd5;
        #1;
        check("R8 visible after second edge", {32'd0, reg_rdata}, 64'h1234_5678);
        check_reg(3'd6, "R8 upper input");

        // R4 staging, R7 readback, R5 commit
        do_write(3'd0, 32'h1, "R4 enter hold");
        check_reg(3'd0, "R7 ctrl readback");
        do_write(3'd1, 32'h5555_AAAA, "R4 stage data lo");
        do_write(3'd3, 32'hFFFF_0000, "R4 stage oe lo");
        do_write(3'd4, 32'h0F0F_0F0F, "R4 stage oe hi");
        check_reg(3'd1, "R7 staged readback");
        check_reg(3'd3, "R7 staged oe readback");
        do_write(3'd2, 32'h1357_9BDF, "R5 commit");

        // R6 flush on exit
        do_write(3'd1, 32'hCAFE_F00D, "R4 stage before exit");
        do_write(3'd3, 32'h0000_FFFF, "R4 stage oe before exit");
        do_write(3'd0, 32'h0, "R6 flush on exit");

        // R9 loopback
        do_write(3'd0, 32'h2, "R9 loopback on");
        idle(3);
        check_reg(3'd5, "R9 loopback read lo");
        check_reg(3'd6, "R9 loopback read hi");
        do_write(3'd0, 32'h3, "R9 loopback with hold");
        do_write(3'd0, 32'h0, "R9 loopback off");

        // R10 ignored writes
        do_write(3'd5, 32'hFFFF_FFFF, "R10 write in lo");
        do_write(3'd6, 32'hFFFF_FFFF, "R10 write in hi");
        do_write(3'd7, 32'hFFFF_FFFF, "R10 write offset 7");
        for (int a = 0; a < 5; a++) check_reg(3'(a), "R10 readback unchanged");
        check_reg(3'd7, "R7 offset 7 reads zero");

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0]  a;
            logic [31:0] d;
            a = 3'($urandom % 8);
            d = $urandom;
            if (a == 3'd0) d = d & 32'h3;
            do_write(a, d, "R3/R4/R5/R6/R9 random write");
            if (it % 4 == 0) begin
                pin_in = {$urandom, $urandom};
                idle(3);
                check_reg(3'($urandom % 8), "R7/R8 random read");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule